// File: doc/BRIEF.md
# Preset Copy Count Controller

This block runs a machine for an operator-chosen number of work cycles. Nine selector inputs give the desired count from 1 to 9. A priority encoder turns them into a 4-bit BCD preset. A start pulse clears a BCD event counter and raises a run level that enables the machine. Each completion pulse from the machine advances the counter. An equality comparator watches the counter against the preset at all times. When the two agree, the run level falls and the machine stops.

The start and copy inputs are asynchronous to the block clock. Each passes through a synchronizer chain and a rising-edge detector, which turns it into a one-clock strobe. The run level behaves as a set/reset latch: a start strobe sets it, and equality with the preset clears it. A later start strobe repeats the whole sequence.

Top module: `cc_copy_ctrl`

## Requirements
- R1: While `rst_n` is low, and on release, `run_o` is 0 and `count_o` is 0.
- R2: Selector bit k-1 of `sel_in` alone gives a preset of k (1..9), and `match_n_o` is 0 exactly when `count_o` equals the preset.
- R3: When several selector bits are high, the highest-numbered one sets the preset.
- R4: With no selector bit high the preset is 0, and a start strobe clears the counter but leaves `run_o` at 0.
- R5: A rising edge on `start_in` acts once, on the third rising clock edge after it is first sampled. It clears `count_o` and sets `run_o`. Holding `start_in` high acts only once.
- R6: While `run_o` is 1, each rising edge of `copy_in` advances `count_o` by one, with the same three-edge latency as R5.
- R7: Copy edges that take effect while `run_o` is 0 leave `count_o` unchanged.
- R8: `run_o` falls on the same clock edge on which `count_o` becomes equal to the preset. It also falls when a preset change makes the preset equal to a running count.
- R9: The counter steps through BCD only, wrapping from 9 to 0.
- R10: A start strobe while running restarts the count from 0 and keeps `run_o` at 1.
- R11: When start and copy strobes fall in the same cycle, the start wins and the copy is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_in | input | 9 | Count selectors; bit k-1 selects count k |
| start_in | input | 1 | Asynchronous start request, acts on its rising edge |
| copy_in | input | 1 | Asynchronous completion pulse from the machine |
| run_o | output | 1 | Run level sent to the machine |
| count_o | output | 4 | BCD count of completions since the last start |
| match_n_o | output | 1 | Low while the count equals the preset |

## Verification
The assertions assume that the selector inputs are quasi-static. They may change between operations or at quiet points in a run, but they are not expected to glitch. The assertions also assume that each raw pulse stays high long enough to pass through the synchronizer. The stimulus meets both assumptions. It holds each start or copy pulse high for three clocks and low for three clocks. It changes the selectors only at clock-aligned moments, once on purpose in the middle of a run to reach the wrap and late-match cases. One case makes start and copy edges coincide to exercise the priority rule.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned SEL_N = 9;
  localparam int unsigned DIG_W = 4;
  localparam int unsigned BCD_MAX = 9;

  typedef logic [DIG_W-1:0] bcd_t;

  // Next BCD digit value, wrapping after the largest decimal digit.
  function automatic bcd_t bcd_next(input bcd_t v);
    if (v >= bcd_t'(BCD_MAX)) return '0;
    return v + bcd_t'(1);
  endfunction

  // Highest-numbered active selector gives the preset; none gives zero.
  function automatic bcd_t sel_to_bcd(input logic [SEL_N-1:0] s);
    bcd_t r;
    r = '0;
    for (int i = 0; i < int'(SEL_N); i++)
      if (s[i]) r = bcd_t'(i + 1);
    return r;
  endfunction
endpackage

// File: rtl/cc_pulse_sync.sv
module cc_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic strobe
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= raw;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], raw};
    end
  endgenerate

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= synced;

  assign strobe = synced & ~last_q;

  // R5: an edge yields a one-clock strobe, never two in a row
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/cc_preset_enc.sv
module cc_preset_enc
  import cc_pkg::*;
(
  input  logic [SEL_N-1:0] sel,
  output bcd_t             code
);
  assign code = sel_to_bcd(sel);

  always_comb begin
    a_r2_code_range: assert (code <= bcd_t'(BCD_MAX));
    if (sel == '0) a_r4_none_zero: assert (code == '0);
  end
endmodule

// File: rtl/cc_bcd_counter.sv
module cc_bcd_counter
  import cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output bcd_t value
);
  bcd_t value_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   value_q <= '0;
    else if (clr) value_q <= '0;
    else if (inc) value_q <= bcd_next(value_q);

  assign value = value_q;

  // R9: the count never leaves the decimal digit range
  a_r9_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
    value_q <= bcd_t'(BCD_MAX));
  // R6: an increment without clear always moves the count
  a_r6_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> value_q != $past(value_q));
  // R5: a clear lands on zero
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> value_q == '0);
endmodule

// File: rtl/cc_copy_ctrl.sv
module cc_copy_ctrl
  import cc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_N-1:0] sel_in,
  input  logic             start_in,
  input  logic             copy_in,
  output logic             run_o,
  output logic [DIG_W-1:0] count_o,
  output logic             match_n_o
);
  logic start_stb;
  logic copy_stb;
  bcd_t preset;
  bcd_t count;
  logic run_q;
  logic run_d;
  logic copy_ok;
  logic reach_hit;
  logic match_now;
  logic preset_valid;

  cc_pulse_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .raw(start_in), .strobe(start_stb));

  cc_pulse_sync #(.STAGES(SYNC_STAGES)) u_copy_sync (
    .clk(clk), .rst_n(rst_n), .raw(copy_in), .strobe(copy_stb));

  cc_preset_enc u_enc (.sel(sel_in), .code(preset));

  // Copies count only while running, and a start in the same cycle wins.
  assign copy_ok      = copy_stb & run_q & ~start_stb;
  assign preset_valid = (preset != '0);
  assign match_now    = (count == preset);
  assign reach_hit    = copy_ok & (bcd_next(count) == preset);

  cc_bcd_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_stb), .inc(copy_ok), .value(count));

  always_comb begin
    run_d = run_q;
    if (start_stb)                        run_d = preset_valid;
    else if (run_q && (reach_hit || match_now)) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;

  assign run_o     = run_q;
  assign count_o   = count;
  assign match_n_o = ~match_now;

  // R8: the run level only ever falls when the count equals the preset
  a_r8_drop_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !match_n_o);
  // R7: while idle and without a start, the count holds
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_stb) |=> $stable(count));
  // R4: a start with no selection never begins a run
  a_r4_no_run_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb && !preset_valid) |=> !run_q);
  // R10: a start with a valid preset always runs from zero
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb && preset_valid) |=> (run_q && count == '0));
endmodule

// File: tb/cc_copy_ctrl_bench.sv
module cc_copy_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] sel_in;
  logic       start_in;
  logic       copy_in;
  logic       run_o;
  logic [3:0] count_o;
  logic       match_n_o;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 1'b0;
  string phase = "R1";

  // reference model state
  int m_st1, m_st2, m_stl;
  int m_cp1, m_cp2, m_cpl;
  int m_cnt;
  int m_run;

  always #4 clk = ~clk;

  cc_copy_ctrl u_cc_copy_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .start_in(start_in),
    .copy_in(copy_in), .run_o(run_o), .count_o(count_o), .match_n_o(match_n_o));

  function automatic int want_preset(input logic [8:0] s);
    for (int k = 9; k >= 1; k--)
      if (s[k-1]) return k;
    return 0;
  endfunction

  task automatic model_step();
    int pre, old;
    bit s_go, c_go;
    s_go = (m_st2 == 1) && (m_stl == 0);
    c_go = (m_cp2 == 1) && (m_cpl == 0);
    pre  = want_preset(sel_in);
    old  = m_cnt;
    if (s_go) begin
      m_cnt = 0;
      m_run = (pre != 0) ? 1 : 0;
    end else if (m_run == 1) begin
      if (c_go) m_cnt = (m_cnt + 1) % 10;
      if (m_cnt == pre || old == pre) m_run = 0;
    end
    m_stl = m_st2; m_st2 = m_st1; m_st1 = start_in ? 1 : 0;
    m_cpl = m_cp2; m_cp2 = m_cp1; m_cp1 = copy_in ? 1 : 0;
  endtask

  task automatic compare();
    int exp_match_n;
    exp_match_n = (m_cnt == want_preset(sel_in)) ? 0 : 1;
    vectors++;
    if (run_o !== m_run[0] || count_o !== 4'(m_cnt) || match_n_o !== exp_match_n[0]) begin
      misses++;
      $display("FAIL %s: run=%0b count=%0d match_n=%0b, expected run=%0d count=%0d match_n=%0d",
               phase, run_o, count_o, match_n_o, m_run, m_cnt, exp_match_n);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_start();
    start_in = 1'b1; wait_n(3);
    start_in = 1'b0; wait_n(3);
  endtask

  task automatic pulse_copy();
    copy_in = 1'b1; wait_n(3);
    copy_in = 1'b0; wait_n(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      misses++;
      $display("FAIL watchdog: cycles=%0d, expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; sel_in = '0; start_in = 1'b0; copy_in = 1'b0;
    m_st1 = 0; m_st2 = 0; m_stl = 0; m_cp1 = 0; m_cp2 = 0; m_cpl = 0;
    m_cnt = 0; m_run = 0;
    // R1: reset state
    phase = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); compare();
    end
    rst_n = 1'b1;
    wait_n(2);

    // R2 R5 R6 R8: preset 5, five copies stop the run
    phase = "R2/R5/R6/R8 preset five";
    sel_in = 9'b0_0001_0000;
    wait_n(1);
    pulse_start();
    for (int i = 0; i < 5; i++) pulse_copy();
    start_in = 1'b1; wait_n(8); start_in = 1'b0; wait_n(3); // held start acts once

    // R7: copies while idle are ignored
    phase = "R7 idle copies";
    sel_in = 9'b0_0000_0100;
    wait_n(2);
    for (int i = 0; i < 3; i++) pulse_copy();

    // R3: two selectors, highest (8) wins
    phase = "R3 priority";
    sel_in = 9'b0_1000_0100;
    wait_n(1);
    pulse_start();
    for (int i = 0; i < 8; i++) pulse_copy();

    // R4: no selector, start gives no run
    phase = "R4 none";
    sel_in = '0;
    wait_n(1);
    pulse_start();
    pulse_copy();

    // R10: restart while running
    phase = "R10 restart";
    sel_in = 9'b0_0000_1000;
    wait_n(1);
    pulse_start();
    pulse_copy(); pulse_copy();
    pulse_start();
    for (int i = 0; i < 4; i++) pulse_copy();

    // R11: start and copy edges in the same cycle
    phase = "R11 collision";
    sel_in = 9'b0_0010_0000;
    wait_n(1);
    pulse_start();
    pulse_copy();
    start_in = 1'b1; copy_in = 1'b1; wait_n(3);
    start_in = 1'b0; copy_in = 1'b0; wait_n(3);
    for (int i = 0; i < 6; i++) pulse_copy();

    // R9 R8: preset lowered below the running count, count wraps 9 to 0
    phase = "R9/R8 wrap";
    sel_in = 9'b1_0000_0000;
    wait_n(1);
    pulse_start();
    for (int i = 0; i < 5; i++) pulse_copy();
    sel_in = 9'b0_0000_0010;
    wait_n(1);
    for (int i = 0; i < 8; i++) pulse_copy();

    // R8: preset changed to equal the running count
    phase = "R8 late match";
    sel_in = 9'b1_0000_0000;
    wait_n(1);
    pulse_start();
    for (int i = 0; i < 4; i++) pulse_copy();
    sel_in = 9'b0_0000_1000;
    wait_n(4);
    pulse_copy();

    finish_run();
  end
endmodule